// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Shared Interrupt Output

The block holds four alarm registers for second, minute, hour and day of month, all in BCD. Bit 7 of each register is a repeat bit. On every one-second tick it compares the registers against the current time-of-day inputs. The four repeat bits together set how coarse the comparison is, from "every second" down to "once per month". When the comparison succeeds, a sticky alarm flag is set. A read strobe on the flags location clears it.

A single active-low, open-drain interrupt pin is shared by three sources: the alarm, a watchdog interrupt request from a neighbouring block, and a 512 Hz test tone used for trimming the oscillator. The block drives this pin through an enable signal, `irq_oe`, where 1 pulls the pin low. The alarm reaches the pin only when its enable bit is set. While the system runs on its backup supply, a second enable bit is also required. The tone is allowed only under a specific combination of control inputs, and either interrupt source overrides it.

Top module: `alarm_irq_mux`

## Requirements
- R1: After reset, `alarm_flag` and `irq_oe` are 0 and both enable bits are cleared. All four alarm registers hold 0x00, and with that value no tick sets the flag when the current date is valid (01..31).
- R2: The repeat code is {date[7], hour[7], min[7], sec[7]}. Code 1111 matches on every tick whatever the time. Any code not listed in R3..R6 (for example 0101 or 0111) also matches on every tick.
- R3: Code 1110 matches when the second field equals the alarm second (bits 6:0). The other fields are ignored.
- R4: Code 1100 matches when both minute and second are equal.
- R5: Code 1000 matches when hour (bits 5:0), minute and second are all equal.
- R6: Code 0000 matches only when date (bits 5:0), hour, minute and second are all equal.
- R7: Matching is evaluated only in a cycle with `sec_tick`=1. A match sets `alarm_flag` on the following clock edge. Without a tick the flag does not change, unless a read clears it.
- R8: `flags_rd`=1 clears `alarm_flag` on the next edge. If a match tick arrives in the same cycle, the flag stays set.
- R9: The alarm drives `irq_oe`=1 only while `alarm_flag`=1 and the alarm enable (AE) is set. With `backup_mode`=1, the backup enable (BE) must also be set. An enable write with `ien_wr_en` loads AE from `ien_wr_data[1]` and BE from `ien_wr_data[0]`.
- R10: The tone is active when `osc_stop`=0, `ft_en`=1, AE=0, and either `wdog_steer`=1 or `wdog_reg_zero`=1. While the tone is active, `irq_oe` inverts on the edge after each `tone_strobe`, starting from 0. While the tone is inactive, its phase is held at 0.
- R11: While `wdog_irq`=1, `irq_oe`=1 and the tone is denied. The alarm has the same override.
- R12: An alarm write with `alm_wr_en` loads `alm_wr_data` into the register chosen by `alm_wr_sel`: 0 = second, 1 = minute, 2 = hour, 3 = date.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| alm_wr_en | input | 1 | Alarm register write strobe |
| alm_wr_sel | input | 2 | Alarm register select: 0 sec, 1 min, 2 hour, 3 date |
| alm_wr_data | input | 8 | Alarm register data: bit 7 repeat, bits 6:0 BCD |
| ien_wr_en | input | 1 | Interrupt-enable write strobe |
| ien_wr_data | input | 2 | Bit 1 alarm enable, bit 0 backup enable |
| flags_rd | input | 1 | Flags read strobe, clears the alarm flag |
| cur_sec | input | 8 | Current seconds, BCD (bit 7 ignored) |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse once per second |
| backup_mode | input | 1 | System is running on the backup supply |
| wdog_irq | input | 1 | Watchdog interrupt request to the pin |
| wdog_steer | input | 1 | Watchdog steering bit (1 = to reset) |
| wdog_reg_zero | input | 1 | Watchdog register is zero |
| osc_stop | input | 1 | Oscillator stop bit |
| ft_en | input | 1 | Frequency-test bit |
| tone_strobe | input | 1 | Pulse at 1024 Hz, one per half period of the tone |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_oe | output | 1 | Pull-down enable for the open-drain interrupt pin |

## Verification
Each repeat code is tested twice: once with a time that matches exactly, and once with a time that differs in exactly one field. That field is the coarsest one the code compares, so each test separates a code from its neighbours. For example, the hourly code sees a changed minute, while the per-minute code with the same change must still fire. Two unlisted codes are applied with a time that matches nothing, which separates the every-second fallback from a true comparison. A match held without a tick and a read that arrives in the same cycle as a tick cover the flag timing. The tone is started, stopped by the oscillator stop bit, and overridden by the watchdog request, and the backup supply is toggled against both enable combinations.

// File: rtl/alm_pkg.sv
package alm_pkg;

  localparam int FIELD_W = 8;
  localparam int NUM_FIELDS = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] date;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
  } tod_t;

  typedef enum logic [2:0] {
    GRAN_SECOND = 3'd0,
    GRAN_MINUTE = 3'd1,
    GRAN_HOUR   = 3'd2,
    GRAN_DAY    = 3'd3,
    GRAN_MONTH  = 3'd4
  } gran_e;

  // repeat code ordered {date, hour, min, sec} bit 7
  function automatic gran_e decode_repeat(input tod_t alm);
    logic [3:0] code;
    code = {alm.date[7], alm.hour[7], alm.min[7], alm.sec[7]};
    case (code)
      4'b1110: decode_repeat = GRAN_MINUTE;
      4'b1100: decode_repeat = GRAN_HOUR;
      4'b1000: decode_repeat = GRAN_DAY;
      4'b0000: decode_repeat = GRAN_MONTH;
      default: decode_repeat = GRAN_SECOND;
    endcase
  endfunction

  // per-field equality, index 0 sec .. 3 date
  function automatic logic [3:0] field_equal(input tod_t alm, input tod_t now);
    logic [3:0] eq;
    eq[0] = ((alm.sec  ^ now.sec)  & 8'h7F) == 8'h00;
    eq[1] = ((alm.min  ^ now.min)  & 8'h7F) == 8'h00;
    eq[2] = ((alm.hour ^ now.hour) & 8'h3F) == 8'h00;
    eq[3] = ((alm.date ^ now.date) & 8'h3F) == 8'h00;
    return eq;
  endfunction

  function automatic logic alarm_hit(input gran_e g, input logic [3:0] eq);
    case (g)
      GRAN_MINUTE: alarm_hit = eq[0];
      GRAN_HOUR:   alarm_hit = &eq[1:0];
      GRAN_DAY:    alarm_hit = &eq[2:0];
      GRAN_MONTH:  alarm_hit = &eq[3:0];
      default:     alarm_hit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int AE_BIT = 1,
  parameter int BE_BIT = 0,
  parameter int IEN_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alm_wr_en,
  input  logic [SEL_W-1:0]   alm_wr_sel,
  input  logic [FIELD_W-1:0] alm_wr_data,
  input  logic               ien_wr_en,
  input  logic [IEN_W-1:0]   ien_wr_data,
  output tod_t               alm_set,
  output logic               alm_en,
  output logic               bkp_en
);

  logic [FIELD_W-1:0] reg_q [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        reg_q[g] <= '0;
      else if (alm_wr_en && (alm_wr_sel == SEL_W'(g)))
        reg_q[g] <= alm_wr_data;
    end
  end

  assign alm_set = '{date: reg_q[3], hour: reg_q[2], min: reg_q[1], sec: reg_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_en <= 1'b0;
      bkp_en <= 1'b0;
    end else if (ien_wr_en) begin
      alm_en <= ien_wr_data[AE_BIT];
      bkp_en <= ien_wr_data[BE_BIT];
    end
  end

  // R9: enables change only through an enable write
  assert_ien_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_wr_en |=> ($stable(alm_en) && $stable(bkp_en)));

endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tod_t alm_set,
  input  tod_t now,
  input  logic sec_tick,
  input  logic flags_rd,
  output logic hit,
  output logic alarm_flag
);

  gran_e      gran;
  logic [3:0] eq;
  logic       set_ev;

  assign gran   = decode_repeat(alm_set);
  assign eq     = field_equal(alm_set, now);
  assign hit    = alarm_hit(gran, eq);
  assign set_ev = sec_tick && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm_flag <= 1'b0;
    else if (set_ev)
      alarm_flag <= 1'b1;
    else if (flags_rd)
      alarm_flag <= 1'b0;
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> alarm_flag);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !flags_rd) |=> $stable(alarm_flag));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !(sec_tick && hit)) |=> !alarm_flag);

  // R2: all repeat bits set means any time matches
  assert_every_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_set.sec[7] && alm_set.min[7] && alm_set.hour[7] && alm_set.date[7]) |-> hit);

endmodule

// File: rtl/irq_mux.sv
module irq_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_flag,
  input  logic alm_en,
  input  logic bkp_en,
  input  logic backup_mode,
  input  logic wdog_irq,
  input  logic wdog_steer,
  input  logic wdog_reg_zero,
  input  logic osc_stop,
  input  logic ft_en,
  input  logic tone_strobe,
  output logic alarm_drive,
  output logic tone_on,
  output logic irq_oe
);

  logic tone_q;

  assign alarm_drive = alarm_flag && alm_en && (!backup_mode || bkp_en);
  assign tone_on     = !osc_stop && ft_en && !alm_en && (wdog_steer || wdog_reg_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tone_q <= 1'b0;
    else if (!tone_on)
      tone_q <= 1'b0;
    else if (tone_strobe)
      tone_q <= !tone_q;
  end

  // fixed priority: alarm, watchdog, tone
  always_comb begin
    if (alarm_drive)    irq_oe = 1'b1;
    else if (wdog_irq)  irq_oe = 1'b1;
    else if (tone_on)   irq_oe = tone_q;
    else                irq_oe = 1'b0;
  end

  assert_wdog_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |-> irq_oe);

  assert_backup_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (backup_mode && !bkp_en && !wdog_irq && !tone_on) |-> !irq_oe);

  assert_tone_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_on && $past(tone_on) && $past(tone_strobe) && !wdog_irq && !alarm_drive
     && !$past(wdog_irq) && !$past(alarm_drive)) |-> (irq_oe != $past(irq_oe)));

  assert_tone_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_on && !wdog_irq && !alarm_drive) |-> !irq_oe);

endmodule

// File: rtl/alarm_irq_mux.sv
module alarm_irq_mux
  import alm_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int IEN_W = 2,
  parameter int AE_BIT = 1,
  parameter int BE_BIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alm_wr_en,
  input  logic [SEL_W-1:0]   alm_wr_sel,
  input  logic [FIELD_W-1:0] alm_wr_data,
  input  logic               ien_wr_en,
  input  logic [IEN_W-1:0]   ien_wr_data,
  input  logic               flags_rd,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic               sec_tick,
  input  logic               backup_mode,
  input  logic               wdog_irq,
  input  logic               wdog_steer,
  input  logic               wdog_reg_zero,
  input  logic               osc_stop,
  input  logic               ft_en,
  input  logic               tone_strobe,
  output logic               alarm_flag,
  output logic               irq_oe
);

  tod_t alm_set;
  tod_t now;
  logic alm_en;
  logic bkp_en;
  logic hit;
  logic alarm_drive;
  logic tone_on;

  assign now = '{date: cur_date, hour: cur_hour, min: cur_min, sec: cur_sec};

  alm_regs #(
    .SEL_W(SEL_W), .AE_BIT(AE_BIT), .BE_BIT(BE_BIT), .IEN_W(IEN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .alm_wr_en(alm_wr_en), .alm_wr_sel(alm_wr_sel), .alm_wr_data(alm_wr_data),
    .ien_wr_en(ien_wr_en), .ien_wr_data(ien_wr_data),
    .alm_set(alm_set), .alm_en(alm_en), .bkp_en(bkp_en)
  );

  alm_match u_match (
    .clk(clk), .rst_n(rst_n),
    .alm_set(alm_set), .now(now),
    .sec_tick(sec_tick), .flags_rd(flags_rd),
    .hit(hit), .alarm_flag(alarm_flag)
  );

  irq_mux u_mux (
    .clk(clk), .rst_n(rst_n),
    .alarm_flag(alarm_flag), .alm_en(alm_en), .bkp_en(bkp_en),
    .backup_mode(backup_mode), .wdog_irq(wdog_irq),
    .wdog_steer(wdog_steer), .wdog_reg_zero(wdog_reg_zero),
    .osc_stop(osc_stop), .ft_en(ft_en), .tone_strobe(tone_strobe),
    .alarm_drive(alarm_drive), .tone_on(tone_on), .irq_oe(irq_oe)
  );

  // R9: the alarm never drives the pin without its enable
  assert_alarm_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !alm_en && !wdog_irq && !tone_on) |-> !irq_oe);

endmodule

// File: tb/alarm_irq_mux_tb.sv
module alarm_irq_mux_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alm_wr_en = 1'b0;
  logic [1:0] alm_wr_sel = '0;
  logic [7:0] alm_wr_data = '0;
  logic       ien_wr_en = 1'b0;
  logic [1:0] ien_wr_data = '0;
  logic       flags_rd = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_date = 8'h01;
  logic       sec_tick = 1'b0;
  logic       backup_mode = 1'b0;
  logic       wdog_irq = 1'b0;
  logic       wdog_steer = 1'b0;
  logic       wdog_reg_zero = 1'b0;
  logic       osc_stop = 1'b0;
  logic       ft_en = 1'b0;
  logic       tone_strobe = 1'b0;
  logic       alarm_flag;
  logic       irq_oe;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = !clk;

  alarm_irq_mux u_dut (
    .clk(clk), .rst_n(rst_n),
    .alm_wr_en(alm_wr_en), .alm_wr_sel(alm_wr_sel), .alm_wr_data(alm_wr_data),
    .ien_wr_en(ien_wr_en), .ien_wr_data(ien_wr_data), .flags_rd(flags_rd),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .sec_tick(sec_tick), .backup_mode(backup_mode), .wdog_irq(wdog_irq),
    .wdog_steer(wdog_steer), .wdog_reg_zero(wdog_reg_zero), .osc_stop(osc_stop),
    .ft_en(ft_en), .tone_strobe(tone_strobe),
    .alarm_flag(alarm_flag), .irq_oe(irq_oe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_alarm(input logic [1:0] sel, input logic [7:0] d);
    alm_wr_en = 1'b1; alm_wr_sel = sel; alm_wr_data = d;
    step();
    alm_wr_en = 1'b0;
  endtask

  task automatic set_alarm(input logic [7:0] dt, input logic [7:0] hr,
                           input logic [7:0] mn, input logic [7:0] sc);
    wr_alarm(2'd0, sc); wr_alarm(2'd1, mn); wr_alarm(2'd2, hr); wr_alarm(2'd3, dt);
  endtask

  task automatic wr_ien(input logic ae, input logic be);
    ien_wr_en = 1'b1; ien_wr_data = {ae, be};
    step();
    ien_wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] dt, input logic [7:0] hr,
                          input logic [7:0] mn, input logic [7:0] sc);
    cur_date = dt; cur_hour = hr; cur_min = mn; cur_sec = sc;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    step();
    sec_tick = 1'b0;
  endtask

  task automatic rd_flags();
    flags_rd = 1'b1;
    step();
    flags_rd = 1'b0;
  endtask

  task automatic strobe();
    tone_strobe = 1'b1;
    step();
    tone_strobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "flag after reset", alarm_flag, 1'b0);
    check("R1", "irq_oe after reset", irq_oe, 1'b0);
    set_time(8'h01, 8'h00, 8'h00, 8'h00);
    tick();
    check("R1", "cleared alarm never matches", alarm_flag, 1'b0);
    check("R1", "enables cleared, pin idle", irq_oe, 1'b0);
  endtask

  task automatic t_every_second();
    wr_ien(1'b1, 1'b0);
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(8'h17, 8'h09, 8'h33, 8'h51);
    tick();
    check("R2", "code 1111 flag", alarm_flag, 1'b1);
    check("R9", "enabled alarm drives pin", irq_oe, 1'b1);
    rd_flags();
    check("R8", "read clears flag", alarm_flag, 1'b0);
    // code 0101: date=0 hour=1 min=0 sec=1
    set_alarm(8'h05, 8'h81, 8'h07, 8'h82);
    tick();
    check("R2", "unlisted code 0101 fires", alarm_flag, 1'b1);
    rd_flags();
    // code 0111
    set_alarm(8'h05, 8'h81, 8'h87, 8'h82);
    tick();
    check("R2", "unlisted code 0111 fires", alarm_flag, 1'b1);
    rd_flags();
    check("R12", "second write ok after reads", alarm_flag, 1'b0);
  endtask

  task automatic t_minute();
    set_alarm(8'h80, 8'h80, 8'h80, 8'h30);
    set_time(8'h02, 8'h11, 8'h59, 8'h30);
    tick();
    check("R3", "second match fires", alarm_flag, 1'b1);
    rd_flags();
    set_time(8'h02, 8'h11, 8'h59, 8'h31);
    tick();
    check("R3", "second mismatch silent", alarm_flag, 1'b0);
    // seconds bit 7 of current time ignored
    set_time(8'h02, 8'h11, 8'h00, 8'hB0);
    tick();
    check("R3", "current bit7 ignored", alarm_flag, 1'b1);
    rd_flags();
  endtask

  task automatic t_hour();
    set_alarm(8'h80, 8'h80, 8'h42, 8'h15);
    set_time(8'h05, 8'h07, 8'h42, 8'h15);
    tick();
    check("R4", "min+sec match fires", alarm_flag, 1'b1);
    rd_flags();
    set_time(8'h05, 8'h07, 8'h43, 8'h15);
    tick();
    check("R4", "minute mismatch silent", alarm_flag, 1'b0);
  endtask

  task automatic t_day();
    set_alarm(8'h80, 8'h23, 8'h42, 8'h15);
    set_time(8'h09, 8'h23, 8'h42, 8'h15);
    tick();
    check("R5", "h+m+s match fires", alarm_flag, 1'b1);
    rd_flags();
    set_time(8'h09, 8'h22, 8'h42, 8'h15);
    tick();
    check("R5", "hour mismatch silent", alarm_flag, 1'b0);
  endtask

  task automatic t_month();
    set_alarm(8'h31, 8'h23, 8'h59, 8'h58);
    set_time(8'h31, 8'h23, 8'h59, 8'h58);
    tick();
    check("R6", "full match fires", alarm_flag, 1'b1);
    rd_flags();
    set_time(8'h30, 8'h23, 8'h59, 8'h58);
    tick();
    check("R6", "date mismatch silent", alarm_flag, 1'b0);
  endtask

  task automatic t_tick_only();
    set_time(8'h31, 8'h23, 8'h59, 8'h58);
    for (int i = 0; i < 5; i++) step();
    check("R7", "match without tick ignored", alarm_flag, 1'b0);
    sec_tick = 1'b1;
    #1;
    check("R7", "flag not set before edge", alarm_flag, 1'b0);
    step();
    sec_tick = 1'b0;
    check("R7", "flag set on edge after tick", alarm_flag, 1'b1);
    // same-cycle read and match tick: set wins
    sec_tick = 1'b1; flags_rd = 1'b1;
    step();
    sec_tick = 1'b0; flags_rd = 1'b0;
    check("R8", "set wins over read", alarm_flag, 1'b1);
    rd_flags();
    check("R8", "plain read clears", alarm_flag, 1'b0);
  endtask

  task automatic t_enables();
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    wr_ien(1'b0, 1'b0);
    tick();
    check("R9", "flag set with AE=0", alarm_flag, 1'b1);
    check("R9", "AE=0 pin idle", irq_oe, 1'b0);
    wr_ien(1'b1, 1'b0);
    check("R9", "AE=1 pin driven", irq_oe, 1'b1);
    backup_mode = 1'b1;
    #1;
    check("R9", "backup without BE idle", irq_oe, 1'b0);
    wr_ien(1'b1, 1'b1);
    check("R9", "backup with AE+BE driven", irq_oe, 1'b1);
    backup_mode = 1'b0;
    rd_flags();
    check("R8", "read releases pin", irq_oe, 1'b0);
    set_alarm(8'h00, 8'h00, 8'h00, 8'h00);
    wr_ien(1'b0, 1'b0);
  endtask

  task automatic t_tone();
    ft_en = 1'b1; osc_stop = 1'b0; wdog_steer = 1'b1; wdog_reg_zero = 1'b0;
    step();
    check("R10", "tone starts low", irq_oe, 1'b0);
    strobe();
    check("R10", "after strobe 1", irq_oe, 1'b1);
    step();
    check("R10", "holds between strobes", irq_oe, 1'b1);
    strobe();
    check("R10", "after strobe 2", irq_oe, 1'b0);
    wdog_steer = 1'b0; wdog_reg_zero = 1'b1;
    strobe();
    check("R10", "watchdog zero also allows tone", irq_oe, 1'b1);
    osc_stop = 1'b1;
    strobe();
    check("R10", "stop bit kills tone", irq_oe, 1'b0);
    strobe();
    check("R10", "stays off while stopped", irq_oe, 1'b0);
    osc_stop = 1'b0;
    wdog_reg_zero = 1'b0;
    strobe();
    check("R10", "steer=0, reg nonzero: no tone", irq_oe, 1'b0);
    wdog_reg_zero = 1'b1;
    wr_ien(1'b1, 1'b0);
    strobe();
    check("R10", "AE=1 denies tone", irq_oe, 1'b0);
    wr_ien(1'b0, 1'b0);
  endtask

  task automatic t_priority();
    wdog_irq = 1'b1;
    strobe();
    check("R11", "watchdog overrides tone, strobe 1", irq_oe, 1'b1);
    strobe();
    check("R11", "watchdog overrides tone, strobe 2", irq_oe, 1'b1);
    wdog_irq = 1'b0;
    ft_en = 1'b0;
    step();
    check("R11", "released after watchdog drops", irq_oe, 1'b0);
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    wr_ien(1'b1, 1'b0);
    ft_en = 1'b1; wdog_steer = 1'b1;
    tick();
    strobe();
    check("R11", "alarm holds pin over tone", irq_oe, 1'b1);
    rd_flags();
    check("R11", "alarm released", irq_oe, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_every_second();
    t_minute();
    t_hour();
    t_day();
    t_month();
    t_tick_only();
    t_enables();
    t_tone();
    t_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule